// File: doc/BRIEF.md
# Endpoint Stall Register

This block keeps one stall flag for each endpoint of a USB function, endpoints 0 to 3. Firmware writes a 32-bit word through a plain register write port. Bit 0 of the word belongs to endpoint 0, bit 1 to endpoint 1, bit 2 to endpoint 2 and bit 3 to endpoint 3. The flags come out as registered, one-per-endpoint signals. The transaction engine samples them at the start of each token and answers that endpoint with a STALL handshake. Because the flag only changes on a clock edge, a write made while a transfer is in progress takes effect from the next transfer onward.

Hardware can also clear the flags. When the function receives an 8-byte SETUP request that it decodes itself, the protocol engine pulses an input, and that pulse clears the endpoint 0 flag. While the engine holds its SETUP-pending flag, firmware cannot set the endpoint 0 flag. When the auto-clear enable is on, each endpoint's flag clears on the cycle after the engine reports that it sent a STALL handshake on that endpoint. The readback word shows the four flags in bits 3..0 and zero in every other bit.

There is no streaming data path here. Every pin is a plain control or status signal sampled once per clock, so no pin has a handshake and there is no back-pressure.

Top module: `usb_ep_halt_reg`

## Requirements
- R1: After reset all four stall flags are 0 and the readback word is 0.
- R2: A write sets flag i (endpoint i, word bit i, i in 0..3) when bit i of the word is 1. The flag and readback bit i show 1 from the clock edge that accepts the write.
- R3: A write with bit i equal to 0 clears flag i at the same edge.
- R4: Readback bits 31..4 always read 0, and readback bits 3..0 always equal the four stall flags.
- R5: Bits 31..4 of a write word change no flag.
- R6: A pulse on the decoded-SETUP input clears the endpoint 0 flag at that edge and leaves flags 1..3 unchanged.
- R7: While the SETUP-pending input is 1, a write with bit 0 set leaves the endpoint 0 flag unchanged, and the other bits of the same write still take effect.
- R8: With auto-clear enabled, a stall-sent pulse for endpoint i clears flag i at that edge. With auto-clear disabled, a stall-sent pulse has no effect.
- R9: If a hardware clear (decoded SETUP or auto-clear) and a firmware write to the same flag fall in the same cycle, the flag ends up 0.
- R10: In a cycle with no write and no hardware clear, every flag keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the stall register |
| wr_data | input | 32 | Write word; bit i is endpoint i |
| setup_rcvd | input | 1 | Pulse: a function-decoded 8-byte SETUP request was received |
| setup_pend | input | 1 | Level: a SETUP transaction is pending |
| autoclr_en | input | 1 | Auto stall-clear enable from the control register |
| stall_sent | input | 4 | Pulse per endpoint: a STALL handshake was sent |
| halt_flags | output | 4 | Registered stall flag per endpoint |
| rd_data | output | 32 | Readback word |

## Verification
The assertions check on every cycle that a decoded SETUP leaves endpoint 0 unstalled, that an auto-clear event clears its endpoint, and that an unblocked write of 1 sets its bit. They also check that a blocked write to endpoint 0 leaves the bit at 0 and that the flags hold in idle cycles. Some cases need a chosen prior state or a specific combination of inputs, so only the bench's scenarios show them. These are reserved write bits having no effect, stall-sent pulses being ignored with auto-clear off, the exact bit-to-endpoint mapping in readback, and hardware clears winning over conflicting writes.

// File: rtl/usb_halt_pkg.sv
package usb_halt_pkg;
  localparam int unsigned EP_COUNT_DFLT = 4;
  localparam int unsigned REG_W_DFLT    = 32;

  // Next-state controls for one stall flag.
  typedef struct packed {
    logic clr;   // hardware clear, dominant
    logic take;  // firmware write accepted for this bit
    logic val;   // value carried by the write
  } halt_ctl_t;
endpackage

// File: rtl/halt_hw_clear.sv
module halt_hw_clear #(
  parameter int unsigned NUM_EP = usb_halt_pkg::EP_COUNT_DFLT
) (
  input  logic              setup_rcvd,
  input  logic              autoclr_en,
  input  logic [NUM_EP-1:0] stall_sent,
  output logic [NUM_EP-1:0] hw_clr
);
  for (genvar i = 0; i < NUM_EP; i++) begin : g_clr
    if (i == 0) begin : g_ctrl_ep
      // The control endpoint also clears on a locally decoded SETUP.
      assign hw_clr[i] = setup_rcvd | (autoclr_en & stall_sent[i]);
    end else begin : g_data_ep
      assign hw_clr[i] = autoclr_en & stall_sent[i];
    end
  end
endmodule

// File: rtl/halt_wr_gate.sv
module halt_wr_gate #(
  parameter int unsigned NUM_EP = usb_halt_pkg::EP_COUNT_DFLT
) (
  input  logic              wr_en,
  input  logic [NUM_EP-1:0] wr_bits,
  input  logic              setup_pend,
  output logic [NUM_EP-1:0] wr_take,
  output logic [NUM_EP-1:0] wr_val
);
  assign wr_val = wr_bits;

  for (genvar i = 0; i < NUM_EP; i++) begin : g_gate
    if (i == 0) begin : g_ctrl_ep
      // Setting endpoint 0 is refused while a SETUP is pending.
      assign wr_take[i] = wr_en & ~(setup_pend & wr_bits[i]);
    end else begin : g_data_ep
      assign wr_take[i] = wr_en;
    end
  end
endmodule

// File: rtl/ep_halt_cell.sv
module ep_halt_cell
  import usb_halt_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  halt_ctl_t ctl,
  output logic      halt_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        halt_q <= 1'b0;
    else if (ctl.clr)  halt_q <= 1'b0;
    else if (ctl.take) halt_q <= ctl.val;
  end
endmodule

// File: rtl/usb_ep_halt_reg.sv
module usb_ep_halt_reg
  import usb_halt_pkg::*;
#(
  parameter int unsigned NUM_EP = EP_COUNT_DFLT,
  parameter int unsigned REG_W  = REG_W_DFLT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              setup_rcvd,
  input  logic              setup_pend,
  input  logic              autoclr_en,
  input  logic [NUM_EP-1:0] stall_sent,
  output logic [NUM_EP-1:0] halt_flags,
  output logic [REG_W-1:0]  rd_data
);
  localparam int unsigned PAD_W = REG_W - NUM_EP;

  logic [NUM_EP-1:0] hw_clr;
  logic [NUM_EP-1:0] wr_take;
  logic [NUM_EP-1:0] wr_val;
  logic              unused_rsvd;

  // Reserved write bits are dropped here.
  assign unused_rsvd = ^wr_data[REG_W-1:NUM_EP];

  halt_hw_clear #(.NUM_EP(NUM_EP)) i_hw_clear (
    .setup_rcvd (setup_rcvd),
    .autoclr_en (autoclr_en),
    .stall_sent (stall_sent),
    .hw_clr     (hw_clr)
  );

  halt_wr_gate #(.NUM_EP(NUM_EP)) i_wr_gate (
    .wr_en      (wr_en),
    .wr_bits    (wr_data[NUM_EP-1:0]),
    .setup_pend (setup_pend),
    .wr_take    (wr_take),
    .wr_val     (wr_val)
  );

  for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
    halt_ctl_t ctl;
    assign ctl = '{clr: hw_clr[i], take: wr_take[i], val: wr_val[i]};
    ep_halt_cell i_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .ctl    (ctl),
      .halt_q (halt_flags[i])
    );
  end

  assign rd_data = {{PAD_W{1'b0}}, halt_flags};
endmodule

// File: rtl/usb_ep_halt_chk.sv
module usb_ep_halt_chk #(
  parameter int unsigned NUM_EP = 4,
  parameter int unsigned REG_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [REG_W-1:0]  wr_data,
  input logic              setup_rcvd,
  input logic              setup_pend,
  input logic              autoclr_en,
  input logic [NUM_EP-1:0] stall_sent,
  input logic [NUM_EP-1:0] halt_flags
);
  AST_SETUP_CLR_EP0: assert property (@(posedge clk) disable iff (!rst_n)
    setup_rcvd |=> !halt_flags[0]); // R6

  AST_PEND_BLOCKS_EP0: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && setup_pend && wr_data[0] && !halt_flags[0]) |=> !halt_flags[0]); // R7

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !setup_rcvd && !(autoclr_en && |stall_sent)) |=> $stable(halt_flags)); // R10

  for (genvar i = 0; i < NUM_EP; i++) begin : g_ep_chk
    AST_AUTO_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (autoclr_en && stall_sent[i]) |=> !halt_flags[i]); // R8

    if (i > 0) begin : g_data
      AST_WR_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[i] && !(autoclr_en && stall_sent[i])) |=> halt_flags[i]); // R2
    end
  end
endmodule

bind usb_ep_halt_reg usb_ep_halt_chk #(.NUM_EP(NUM_EP), .REG_W(REG_W)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .wr_data    (wr_data),
  .setup_rcvd (setup_rcvd),
  .setup_pend (setup_pend),
  .autoclr_en (autoclr_en),
  .stall_sent (stall_sent),
  .halt_flags (halt_flags)
);

// File: tb/test_usb_ep_halt_reg.sv
module test_usb_ep_halt_reg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        setup_rcvd = 1'b0;
  logic        setup_pend = 1'b0;
  logic        autoclr_en = 1'b0;
  logic [3:0]  stall_sent = '0;
  logic [3:0]  halt_flags;
  logic [31:0] rd_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [3:0]  model = '0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  usb_ep_halt_reg i_usb_ep_halt_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .setup_rcvd(setup_rcvd), .setup_pend(setup_pend), .autoclr_en(autoclr_en),
    .stall_sent(stall_sent), .halt_flags(halt_flags), .rd_data(rd_data)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Driver: applies one cycle of stimulus and queues the expected result.
  task automatic step(input bit wr, input logic [31:0] d, input bit srcv,
                      input bit spend, input bit ac, input logic [3:0] sent,
                      input string tag);
    logic [3:0] nxt;
    @(negedge clk);
    wr_en = wr; wr_data = d; setup_rcvd = srcv; setup_pend = spend;
    autoclr_en = ac; stall_sent = sent;
    for (int i = 0; i < 4; i++) begin
      if ((i == 0 && srcv) || (ac && sent[i]))       nxt[i] = 1'b0;
      else if (wr && !(i == 0 && spend && d[0]))     nxt[i] = d[i];
      else                                           nxt[i] = model[i];
    end
    model = nxt;
    exp_q.push_back({28'h0, nxt});
    tag_q.push_back(tag);
  endtask

  // Monitor: compares after each edge that consumed a queued stimulus.
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check({t, " rd_data (R4)"}, rd_data, e);
      check({t, " halt_flags"}, {28'h0, halt_flags}, e);
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset rd_data", rd_data, 32'h0);
    check("R1 reset flags", {28'h0, halt_flags}, 32'h0);
    rst_n = 1'b1;
    step(1, 32'h1, 0, 0, 0, 4'h0, "R2 set ep0");
    step(1, 32'h4, 0, 0, 0, 4'h0, "R2 set ep2 only");
    step(1, 32'hF, 0, 0, 0, 4'h0, "R2 set all");
    step(1, 32'h0, 0, 0, 0, 4'h0, "R3 clear all");
    step(1, 32'hFFFF_FFF5, 0, 0, 0, 4'h0, "R5 reserved bits ignored");
    step(1, 32'hA, 0, 0, 0, 4'h0, "R3 write mix");
    step(0, 32'hFFFF_FFFF, 0, 0, 0, 4'h0, "R10 idle hold");
    step(1, 32'hF, 0, 0, 0, 4'h0, "R2 set all again");
    step(0, 32'h0, 1, 0, 0, 4'h0, "R6 setup clears ep0");
    step(1, 32'h0, 0, 0, 0, 4'h0, "R3 clear");
    step(1, 32'hF, 0, 1, 0, 4'h0, "R7 pend blocks ep0");
    step(0, 32'h0, 0, 1, 0, 4'h0, "R10 hold under pend");
    step(1, 32'hF, 0, 0, 0, 4'h0, "R7 unblocked set");
    step(0, 32'h0, 0, 0, 0, 4'hF, "R8 sent ignored w/o autoclr");
    step(0, 32'h0, 0, 0, 1, 4'h6, "R8 autoclr ep1 ep2");
    step(0, 32'h0, 0, 0, 1, 4'h1, "R8 autoclr ep0");
    step(1, 32'hF, 0, 0, 1, 4'h8, "R9 autoclr beats write");
    step(1, 32'hF, 1, 0, 0, 4'h0, "R9 setup beats write");
    step(0, 32'h0, 0, 0, 1, 4'h0, "R10 autoclr no pulse");
    @(posedge clk); #3;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule